// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in ordinary memory. A requester hands it a virtual page number, the kind of access (read or write) and the privilege level (user or supervisor), together with the page number of the top-level directory taken from a control register. The walker fetches one directory entry and then one table entry through a word-wide memory port. It returns either the physical page number with the effective permission and caching attributes, or a two-bit fault code that tells a missing mapping apart from a permission violation and names the level at which the walk stopped.

When a walk ends in a translation, the walker also keeps the usage bookkeeping in memory up to date. It sets the accessed bit in both entries and the dirty bit in the table entry on a write. Each entry is written back only if one of those bits actually changes. One walk is in progress at a time. The memory port runs one operation at a time, and each operation waits for a response-valid strobe.

Top module: `ptab_walker`

## Requirements
- R1: The directory entry is read at byte address {dir_base_page, vpn[19:10], 2'b00}, and the table entry at {directory entry bits 31:12, vpn[9:0], 2'b00}.
- R2: A request is taken only when req_ready is high, that is when no walk is running. req_vpn, req_write, req_user and dir_base_page are sampled at that edge. Requests presented during a walk are ignored and start no memory traffic.
- R3: While a memory read or write waits for mem_rsp_valid, the walker keeps the strobe, mem_addr and mem_wdata unchanged. mem_rd and mem_wr are never high together.
- R4: A directory entry with bit 0 (present) clear ends the walk with resp_fault=1 and code 2'b00. No table read and no write take place, and all of that entry's other bits are ignored.
- R5: A table entry with bit 0 clear ends the walk with code 2'b10 and no write.
- R6: The effective write right is the AND of bit 1 in both entries, and the effective user right is the AND of bit 2 in both. A write without the write right, or a user access without the user right, ends the walk with a protection fault and no write. The code is 2'b01 when the directory's own bits already deny the access, and 2'b11 otherwise.
- R7: A walk that succeeds reports resp_fault=0 and code 2'b00, with resp_ppn = table entry bits 31:12. It also reports resp_writable and resp_user (the effective rights), resp_global (table bit 8), resp_wthru (bit 3 of either entry) and resp_nocache (bit 4 of either entry).
- R8: On success the directory entry is written back with bit 5 (accessed) set, but only if that bit was clear. The table entry is then written back with bit 5 set, and bit 6 (dirty) set on a write, but only if this changes it. The directory write comes first, and every other bit is kept.
- R9: resp_valid is a one-cycle pulse. Counting from the accepting edge, with memory latency L, it rises after L+2 edges for a directory fault and after 2L+4 edges for a table-level fault. A success takes 2L+4 edges plus L+1 for each write-back.
- R10: After a reset cycle (rst_n low at a clock edge), req_ready is 1 and resp_valid, mem_rd and mem_wr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | High when idle and able to take a request |
| req_vpn | input | 20 | Virtual page number (address bits 31:12) |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| dir_base_page | input | 20 | Page number of the directory (control register) |
| mem_rd | output | 1 | Memory read request, held until the response |
| mem_wr | output | 1 | Memory write request, held until the response |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory response strobe for the pending operation |
| mem_rdata | input | 32 | Read data, valid with mem_rsp_valid |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_fault_code | output | 2 | Bit 1: level (1 = table), bit 0: kind (1 = protection) |
| resp_ppn | output | 20 | Physical page number (zero on a fault) |
| resp_writable | output | 1 | Effective write right |
| resp_user | output | 1 | Effective user right |
| resp_global | output | 1 | Global flag of the table entry |
| resp_wthru | output | 1 | Write-through requested by either entry |
| resp_nocache | output | 1 | Caching disabled by either entry |

## Verification
The memory model's latency is varied from zero to two wait cycles from one walk to the next. For every walk, the bench predicts from the R9 formula the exact edge on which resp_valid rises. It counts clock edges from the accepting edge and samples each outcome on the falling edge that follows. Memory contents, the read and write addresses and the write counts are compared only after the response pulse, when every write-back has finished. Hold stability during the wait cycles is checked by the memory model at each falling edge of an operation.

// File: rtl/ptw_pkg.sv
// Shared definitions for the page table walker: walk states, entry bit
// positions and fault code values. Assumes 32-bit entries.
package ptw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_DIR,
        S_CHK_DIR,
        S_RD_TBL,
        S_CHK_TBL,
        S_WB_DIR,
        S_WB_TBL,
        S_DONE,
        S_FAULT
    } walk_state_e;

    // Bit 1 of a fault code is the level, bit 0 is the kind.
    typedef enum logic [1:0] {
        FC_DIR_ABSENT = 2'b00,
        FC_DIR_PROT   = 2'b01,
        FC_TBL_ABSENT = 2'b10,
        FC_TBL_PROT   = 2'b11
    } fault_code_e;

    localparam int unsigned BIT_PRESENT  = 0;
    localparam int unsigned BIT_WRITE    = 1;
    localparam int unsigned BIT_USER     = 2;
    localparam int unsigned BIT_WTHRU    = 3;
    localparam int unsigned BIT_NOCACHE  = 4;
    localparam int unsigned BIT_ACCESSED = 5;
    localparam int unsigned BIT_DIRTY    = 6;
    localparam int unsigned BIT_GLOBAL   = 8;

endpackage

// File: rtl/ptw_addr_gen.sv
// Entry address generator. For each level it forms the byte address
// "level base page, zero offset" plus the level's index slice scaled by
// the entry size. Level 0 uses the top index slice of the VPN.
// Assumes LEVELS*IDX_W equals the VPN width.
module ptw_addr_gen #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned ENT_LOG2 = 2,
    parameter int unsigned LEVELS   = 2
) (
    input  logic [LEVELS-1:0][ADDR_W-OFF_W-1:0] lvl_base,
    input  logic [LEVELS*IDX_W-1:0]             vpn,
    output logic [LEVELS-1:0][ADDR_W-1:0]       ent_addr
);
    localparam int unsigned PAGE_W = ADDR_W - OFF_W;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int unsigned LSB = (LEVELS - 1 - l) * IDX_W;
        // Base page aligned to a page, plus the scaled index.
        assign ent_addr[l] = {lvl_base[l][PAGE_W-1:0], {OFF_W{1'b0}}}
                           + (ADDR_W'(vpn[LSB +: IDX_W]) << ENT_LOG2);
    end
endmodule

// File: rtl/ptw_entry_eval.sv
// Combinational evaluation of a directory/table entry pair against an
// access. Produces presence, denial, the write-back need and data, and the
// effective attributes. Assumes both entries use the bit layout in ptw_pkg.
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int unsigned ENT_W = 32
) (
    input  logic [ENT_W-1:0] pde,
    input  logic [ENT_W-1:0] pte,
    input  logic             acc_write,
    input  logic             acc_user,
    output logic             dir_present,
    output logic             tbl_present,
    output logic             dir_denied,
    output logic             any_denied,
    output logic             dir_wb_need,
    output logic             tbl_wb_need,
    output logic [ENT_W-1:0] dir_wb_data,
    output logic [ENT_W-1:0] tbl_wb_data,
    output logic             eff_write,
    output logic             eff_user,
    output logic             eff_wthru,
    output logic             eff_nocache,
    output logic             eff_global
);
    localparam logic [ENT_W-1:0] ACC_MASK = ENT_W'(1) << BIT_ACCESSED;
    localparam logic [ENT_W-1:0] DRT_MASK = ENT_W'(1) << BIT_DIRTY;

    // Presence and combined rights.
    always_comb begin
        dir_present = pde[BIT_PRESENT];
        tbl_present = pte[BIT_PRESENT];
        eff_write   = pde[BIT_WRITE] & pte[BIT_WRITE];
        eff_user    = pde[BIT_USER]  & pte[BIT_USER];
        eff_wthru   = pde[BIT_WTHRU]   | pte[BIT_WTHRU];
        eff_nocache = pde[BIT_NOCACHE] | pte[BIT_NOCACHE];
        eff_global  = pte[BIT_GLOBAL];
    end

    // Protection decision; the directory alone may already deny.
    always_comb begin
        dir_denied = (acc_write & ~pde[BIT_WRITE]) | (acc_user & ~pde[BIT_USER]);
        any_denied = (acc_write & ~eff_write)      | (acc_user & ~eff_user);
    end

    // Accessed/dirty update values and whether a write is needed.
    always_comb begin
        dir_wb_data = pde | ACC_MASK;
        tbl_wb_data = pte | ACC_MASK | (acc_write ? DRT_MASK : '0);
        dir_wb_need = ~pde[BIT_ACCESSED];
        tbl_wb_need = ~pte[BIT_ACCESSED] | (acc_write & ~pte[BIT_DIRTY]);
    end
endmodule

// File: rtl/ptw_walk_ctrl.sv
// Walk sequencer. It steps through the directory read and check, the table
// read and check, the optional write-backs and the result cycle, and records
// the fault code. Assumes the memory returns exactly one mem_rsp_valid per
// operation, and only while that operation is requested.
module ptw_walk_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_rsp_valid,
    input  logic        dir_present,
    input  logic        tbl_present,
    input  logic        dir_denied,
    input  logic        any_denied,
    input  logic        dir_wb_need,
    input  logic        tbl_wb_need,
    output walk_state_e state,
    output logic        req_ready,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        resp_valid,
    output logic        resp_fault,
    output logic [1:0]  fault_code
);
    walk_state_e state_q, state_d;
    fault_code_e code_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_RD_DIR;
            S_RD_DIR:  if (mem_rsp_valid) state_d = S_CHK_DIR;
            S_CHK_DIR: state_d = dir_present ? S_RD_TBL : S_FAULT;
            S_RD_TBL:  if (mem_rsp_valid) state_d = S_CHK_TBL;
            S_CHK_TBL: begin
                if (!tbl_present || any_denied) state_d = S_FAULT;
                else if (dir_wb_need)           state_d = S_WB_DIR;
                else if (tbl_wb_need)           state_d = S_WB_TBL;
                else                            state_d = S_DONE;
            end
            S_WB_DIR:  if (mem_rsp_valid) state_d = tbl_wb_need ? S_WB_TBL : S_DONE;
            S_WB_TBL:  if (mem_rsp_valid) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            S_FAULT:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Fault code capture at the check steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= FC_DIR_ABSENT;
        end else if (state_q == S_CHK_DIR && !dir_present) begin
            code_q <= FC_DIR_ABSENT;
        end else if (state_q == S_CHK_TBL) begin
            if (!tbl_present)    code_q <= FC_TBL_ABSENT;
            else if (dir_denied) code_q <= FC_DIR_PROT;
            else                 code_q <= FC_TBL_PROT;
        end
    end

    // State-decoded outputs.
    always_comb begin
        state      = state_q;
        req_ready  = (state_q == S_IDLE);
        mem_rd     = (state_q == S_RD_DIR) || (state_q == S_RD_TBL);
        mem_wr     = (state_q == S_WB_DIR) || (state_q == S_WB_TBL);
        resp_valid = (state_q == S_DONE) || (state_q == S_FAULT);
        resp_fault = (state_q == S_FAULT);
        fault_code = resp_fault ? code_q : 2'b00;
    end

    // R9
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rsp_valid) |=> mem_rd);

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_rsp_valid) |=> mem_wr);
endmodule

// File: rtl/ptab_walker.sv
// Two-level page table walker top. It captures the request, holds the two
// fetched entries, routes the entry address and write-back data to the memory
// port, and drives the result. Assumes entries are ADDR_W bits wide and that
// LEVELS*IDX_W equals ADDR_W-OFF_W.
module ptab_walker
    import ptw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned ENT_LOG2 = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [2*IDX_W-1:0]       req_vpn,
    input  logic                     req_write,
    input  logic                     req_user,
    input  logic [ADDR_W-OFF_W-1:0]  dir_base_page,
    output logic                     mem_rd,
    output logic                     mem_wr,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [ADDR_W-1:0]        mem_wdata,
    input  logic                     mem_rsp_valid,
    input  logic [ADDR_W-1:0]        mem_rdata,
    output logic                     resp_valid,
    output logic                     resp_fault,
    output logic [1:0]               resp_fault_code,
    output logic [ADDR_W-OFF_W-1:0]  resp_ppn,
    output logic                     resp_writable,
    output logic                     resp_user,
    output logic                     resp_global,
    output logic                     resp_wthru,
    output logic                     resp_nocache
);
    localparam int unsigned LEVELS = 2;
    localparam int unsigned PAGE_W = ADDR_W - OFF_W;
    localparam int unsigned VPN_W  = LEVELS * IDX_W;

    walk_state_e              state;
    logic [VPN_W-1:0]         vpn_q;
    logic                     wr_q, usr_q;
    logic [PAGE_W-1:0]        base_q;
    logic [ADDR_W-1:0]        pde_q, pte_q;

    logic [LEVELS-1:0][PAGE_W-1:0] lvl_base;
    logic [LEVELS-1:0][ADDR_W-1:0] ent_addr;

    logic dir_present, tbl_present, dir_denied, any_denied;
    logic dir_wb_need, tbl_wb_need;
    logic [ADDR_W-1:0] dir_wb_data, tbl_wb_data;
    logic eff_write, eff_user, eff_wthru, eff_nocache, eff_global;

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            wr_q   <= 1'b0;
            usr_q  <= 1'b0;
            base_q <= '0;
        end else if (req_valid && req_ready) begin
            vpn_q  <= req_vpn;
            wr_q   <= req_write;
            usr_q  <= req_user;
            base_q <= dir_base_page;
        end
    end

    // Entry capture on each read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pde_q <= '0;
            pte_q <= '0;
        end else if (mem_rsp_valid && state == S_RD_DIR) begin
            pde_q <= mem_rdata;
        end else if (mem_rsp_valid && state == S_RD_TBL) begin
            pte_q <= mem_rdata;
        end
    end

    assign lvl_base[0] = base_q;
    assign lvl_base[1] = pde_q[ADDR_W-1:OFF_W];

    ptw_addr_gen #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .OFF_W    (OFF_W),
        .ENT_LOG2 (ENT_LOG2),
        .LEVELS   (LEVELS)
    ) addr_gen_i (
        .lvl_base (lvl_base),
        .vpn      (vpn_q),
        .ent_addr (ent_addr)
    );

    ptw_entry_eval #(
        .ENT_W (ADDR_W)
    ) eval_i (
        .pde         (pde_q),
        .pte         (pte_q),
        .acc_write   (wr_q),
        .acc_user    (usr_q),
        .dir_present (dir_present),
        .tbl_present (tbl_present),
        .dir_denied  (dir_denied),
        .any_denied  (any_denied),
        .dir_wb_need (dir_wb_need),
        .tbl_wb_need (tbl_wb_need),
        .dir_wb_data (dir_wb_data),
        .tbl_wb_data (tbl_wb_data),
        .eff_write   (eff_write),
        .eff_user    (eff_user),
        .eff_wthru   (eff_wthru),
        .eff_nocache (eff_nocache),
        .eff_global  (eff_global)
    );

    ptw_walk_ctrl ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_rsp_valid (mem_rsp_valid),
        .dir_present   (dir_present),
        .tbl_present   (tbl_present),
        .dir_denied    (dir_denied),
        .any_denied    (any_denied),
        .dir_wb_need   (dir_wb_need),
        .tbl_wb_need   (tbl_wb_need),
        .state         (state),
        .req_ready     (req_ready),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .fault_code    (resp_fault_code)
    );

    // Memory address and write data for the operation of the current state.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_RD_DIR: mem_addr = ent_addr[0];
            S_RD_TBL: mem_addr = ent_addr[1];
            S_WB_DIR: begin
                mem_addr  = ent_addr[0];
                mem_wdata = dir_wb_data;
            end
            S_WB_TBL: begin
                mem_addr  = ent_addr[1];
                mem_wdata = tbl_wb_data;
            end
            default: ;
        endcase
    end

    // Translation result, zeroed unless the walk succeeded.
    always_comb begin
        if (state == S_DONE) begin
            resp_ppn      = pte_q[ADDR_W-1:OFF_W];
            resp_writable = eff_write;
            resp_user     = eff_user;
            resp_global   = eff_global;
            resp_wthru    = eff_wthru;
            resp_nocache  = eff_nocache;
        end else begin
            resp_ppn      = '0;
            resp_writable = 1'b0;
            resp_user     = 1'b0;
            resp_global   = 1'b0;
            resp_wthru    = 1'b0;
            resp_nocache  = 1'b0;
        end
    end

    // R2
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_rsp_valid) |=> ($stable(mem_addr) && $stable(mem_wdata)));

    // R8
    wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_wdata[BIT_ACCESSED]);

    // R6
    write_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault && wr_q) |-> resp_writable);

    // R6
    user_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault && usr_q) |-> resp_user);
endmodule

// File: tb/ptab_walker_tb_top.sv
`timescale 1ns/1ps
module ptab_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_user;
    logic [19:0] req_vpn, dir_base_page;
    logic        mem_rd, mem_wr, mem_rsp_valid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        resp_valid, resp_fault;
    logic [1:0]  resp_fault_code;
    logic [19:0] resp_ppn;
    logic        resp_writable, resp_user, resp_global, resp_wthru, resp_nocache;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [0:4095];
    int          lat;
    int          rd_cnt, wr_cnt, hold_err;
    logic [31:0] rd_log [0:3];
    logic [31:0] wr_log [0:3];

    always #2.5 clk = ~clk;

    ptab_walker dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_vpn (req_vpn),
        .req_write (req_write), .req_user (req_user), .dir_base_page (dir_base_page),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_rsp_valid (mem_rsp_valid), .mem_rdata (mem_rdata),
        .resp_valid (resp_valid), .resp_fault (resp_fault), .resp_fault_code (resp_fault_code),
        .resp_ppn (resp_ppn), .resp_writable (resp_writable), .resp_user (resp_user),
        .resp_global (resp_global), .resp_wthru (resp_wthru), .resp_nocache (resp_nocache)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: answers the held operation after lat wait cycles and
    // checks that the request is held steady meanwhile.
    initial begin
        int          cnt;
        logic [31:0] op_addr, op_data;
        cnt = 0; op_addr = '0; op_data = '0;
        mem_rsp_valid = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin mem_rsp_valid = 1'b0; cnt = 0; end
            if (rst_n && (mem_rd || mem_wr)) begin
                if (cnt == 0) begin op_addr = mem_addr; op_data = mem_wdata; end
                else if (mem_addr !== op_addr || mem_wdata !== op_data) hold_err++;
                if (mem_rd && mem_wr) hold_err++;
                if (cnt == lat) begin
                    mem_rsp_valid = 1'b1;
                    if (mem_rd) begin
                        mem_rdata = mem[mem_addr[13:2]];
                        if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
                        rd_cnt++;
                    end else begin
                        mem[mem_addr[13:2]] = mem_wdata;
                        if (wr_cnt < 4) wr_log[wr_cnt] = mem_addr;
                        wr_cnt++;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Launches one walk and returns the edge count to the response.
    task automatic run_walk(input logic [19:0] base_pg, input logic [19:0] vpn,
                            input logic wr, input logic us, output int k);
        rd_cnt = 0; wr_cnt = 0; hold_err = 0;
        for (int i = 0; i < 4; i++) begin rd_log[i] = '0; wr_log[i] = '0; end
        @(negedge clk);
        chk("R2", "ready while idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vpn = vpn; req_write = wr; req_user = us; dir_base_page = base_pg;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_vpn = ~vpn; dir_base_page = ~base_pg; // R2: sampled at accept only
        k = 0;
        while (!resp_valid && k < 300) begin
            @(posedge clk);
            k++;
            @(negedge clk);
        end
    endtask

    initial begin
        int done_walks;
        done_walks = 0;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        lat = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_vpn = '0; req_write = 1'b0; req_user = 1'b0;
        dir_base_page = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10", "req_ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R10", "resp_valid after reset", {31'd0, resp_valid}, 32'd0);
        chk("R10", "mem_rd after reset", {31'd0, mem_rd}, 32'd0);
        chk("R10", "mem_wr after reset", {31'd0, mem_wr}, 32'd0);
        rst_n = 1'b1;

        // Sweep of all flag combinations of both entries and all access kinds.
        for (int pf = 0; pf < 16; pf++) begin
            for (int tf = 0; tf < 32; tf++) begin
                for (int acc = 0; acc < 4; acc++) begin
                    int          n, k, kexp, nwd, nwt;
                    logic [31:0] h, pde, pte, dadr, tadr, pde_exp, pte_exp;
                    logic [3:0]  pb;
                    logic [4:0]  tb;
                    logic [9:0]  di, ti;
                    logic [1:0]  tp;
                    logic [19:0] base_pg;
                    logic        wr, us, dir_deny, all_deny;
                    n  = pf * 128 + tf * 4 + acc;
                    pb = 4'(pf); tb = 5'(tf);
                    wr = acc[0]; us = acc[1];
                    lat = n % 3;
                    h  = 32'(n) * 32'h9E37_79B1 + 32'h1234_5677;
                    di = h[9:0]; ti = h[19:10];
                    tp = 2'(1 + (n % 3));
                    base_pg = {h[31:14], 2'b00};
                    pde = {~h[31:14], tp, h[2:0], h[3], 1'b0, 1'b0, pb[3], h[4], h[5], pb[2], pb[1], pb[0]};
                    pte = {h[21:2], h[8:6], h[9], 1'b0, tb[4], tb[3], h[11], h[12], tb[2], tb[1], tb[0]};
                    dadr = {base_pg, di, 2'b00};
                    tadr = {pde[31:12], ti, 2'b00};
                    mem[{2'b00, di}] = pde;
                    mem[{tp, ti}]    = pte;
                    run_walk(base_pg, {di, ti}, wr, us, k);
                    done_walks++;

                    dir_deny = (wr & ~pb[1]) | (us & ~pb[2]);
                    all_deny = (wr & ~(pb[1] & tb[1])) | (us & ~(pb[2] & tb[2]));
                    pde_exp = pde; pte_exp = pte;
                    chk("R1", "directory read address", rd_log[0], dadr);
                    chk("R3", "request held while waiting", 32'(hold_err), 32'd0);
                    if (!pb[0]) begin
                        chk("R4", "dir absent fault", {30'd0, resp_fault, 1'b0}, {30'd0, 1'b1, 1'b0});
                        chk("R4", "dir absent code", {30'd0, resp_fault_code}, 32'd0);
                        chk("R4", "dir absent reads", 32'(rd_cnt), 32'd1);
                        chk("R4", "dir absent writes", 32'(wr_cnt), 32'd0);
                        kexp = lat + 2;
                        chk("R9", "dir fault latency", 32'(k), 32'(kexp));
                    end else begin
                        chk("R1", "table read address", rd_log[1], tadr);
                        chk("R1", "read count", 32'(rd_cnt), 32'd2);
                        if (!tb[0]) begin
                            chk("R5", "table absent fault", {31'd0, resp_fault}, 32'd1);
                            chk("R5", "table absent code", {30'd0, resp_fault_code}, 32'd2);
                            chk("R5", "table absent writes", 32'(wr_cnt), 32'd0);
                            kexp = 2 * lat + 4;
                        end else if (all_deny) begin
                            chk("R6", "protection fault", {31'd0, resp_fault}, 32'd1);
                            chk("R6", "protection code", {30'd0, resp_fault_code},
                                dir_deny ? 32'd1 : 32'd3);
                            chk("R6", "protection writes", 32'(wr_cnt), 32'd0);
                            kexp = 2 * lat + 4;
                        end else begin
                            nwd = pb[3] ? 0 : 1;
                            nwt = (!tb[3] || (wr && !tb[4])) ? 1 : 0;
                            kexp = 2 * lat + 4 + (nwd + nwt) * (lat + 1);
                            pde_exp = pde | 32'h20;
                            pte_exp = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                            chk("R7", "success flag", {30'd0, resp_fault, resp_fault_code}, 32'd0);
                            chk("R7", "ppn", {12'd0, resp_ppn}, {12'd0, pte[31:12]});
                            chk("R7", "attributes",
                                {27'd0, resp_writable, resp_user, resp_global, resp_wthru, resp_nocache},
                                {27'd0, pb[1] & tb[1], pb[2] & tb[2], pte[8],
                                 pde[3] | pte[3], pde[4] | pte[4]});
                            chk("R8", "write count", 32'(wr_cnt), 32'(nwd + nwt));
                            if (nwd == 1) chk("R8", "first write is directory", wr_log[0], dadr);
                            if (nwt == 1) chk("R8", "table write address", wr_log[nwd], tadr);
                        end
                        chk("R9", "table-level latency", 32'(k), 32'(kexp));
                    end
                    chk("R8", "directory entry after walk", mem[{2'b00, di}], pde_exp);
                    chk("R8", "table entry after walk", mem[{tp, ti}], pte_exp);
                    @(negedge clk);
                    chk("R9", "response is one cycle", {31'd0, resp_valid}, 32'd0);
                end
            end
        end

        // R2: requests presented during a walk are ignored.
        begin
            int          k;
            logic [31:0] pde, pte;
            lat = 2;
            pde = {20'h0_0003, 12'h027};
            pte = {20'hA_BCDE, 12'h167};
            mem[{2'b00, 10'h055}] = pde;
            mem[{2'b11, 10'h0AA}] = pte;
            rd_cnt = 0; wr_cnt = 0; hold_err = 0;
            @(negedge clk);
            req_valid = 1'b1; req_vpn = {10'h055, 10'h0AA}; req_write = 1'b0; req_user = 1'b1;
            dir_base_page = 20'h0_0000;
            @(posedge clk);
            @(negedge clk);
            req_vpn = {10'h011, 10'h022}; req_write = 1'b1; dir_base_page = 20'h0_0001;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            k = 0;
            while (!resp_valid && k < 300) begin @(posedge clk); k++; @(negedge clk); end
            chk("R2", "busy request: ppn of first walk", {12'd0, resp_ppn}, 32'h000A_BCDE);
            chk("R2", "busy request: first read address", rd_log[0], 32'h0000_0154);
            chk("R2", "busy request: table read address", rd_log[1], 32'h0000_32A8);
            repeat (10) @(negedge clk);
            chk("R2", "busy request: no extra walk", 32'(rd_cnt + wr_cnt), 32'd2);
            chk("R2", "busy request: idle again", {31'd0, req_ready}, 32'd1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule